// File: doc/BRIEF.md
# Unidirectional Routing Switch Box

This block sits at the crossing of a horizontal and a vertical routing channel. The horizontal channel carries pulses only from left to right. The vertical channel holds a set of tracks that run upward and an equal set that run downward. Every arriving pulse is copied onto a fixed set of candidate destinations. Each copy passes through a gate with its own enable bit. Every output track ORs together the gated copies aimed at it.

The topology is lopsided because nothing ever travels right to left. A left track has three branches: straight on to the right, a turn onto an upward track, and a turn onto a downward track. A vertical track has two branches: it carries on in its own direction, or it turns right. A right output therefore merges three sources, and a top or bottom output merges two. Turns use a fixed rotation: a left track i meets vertical track (i+ROT) mod TRACKS, and a vertical track j turns onto right track (j+ROT) mod TRACKS.

All enable bits load together from one configuration word. The pulse path is gates plus mergers plus one output register. When two enabled sources drive the same merger in the same cycle, the block still sends out a single pulse and raises a collision flag.

Top module: `swbox_top`

## Requirements
- R1: While reset is held and on the first cycle after it, every output and the collision flag are 0. All enable bits reset to 0, so no pulse passes until a configuration is loaded.
- R2: The configuration word is captured at a rising edge where cfgValid is 1. It governs pulses that arrive in later cycles. A pulse arriving in the same cycle as the load still sees the old configuration. When cfgValid is 0 the configuration does not change.
- R3: An output pulse appears exactly one cycle after the input pulse that caused it, and lasts one cycle.
- R4: With TRACKS=2 and ROT=1, left track i reaches three destinations, each with its own enable bit: right track i (bit 3i), upward output (i+1) mod 2 (bit 3i+1), and downward output (i+1) mod 2 (bit 3i+2).
- R5: Upward input j, which enters at the bottom, reaches two destinations: upward output j at the top (bit 6+2j) and right track (j+1) mod 2 (bit 7+2j).
- R6: Downward input j, which enters at the top, reaches two destinations: downward output j at the bottom (bit 10+2j) and right track (j+1) mod 2 (bit 11+2j).
- R7: A branch whose enable bit is 0 passes nothing, even when every input pulses.
- R8: An output pulses when any one of its enabled sources pulses. Two or more enabled sources together still give one pulse.
- R9: The collision flag is 1 in the output cycle exactly when two or more enabled sources pulsed into the same merger one cycle earlier. Otherwise it is 0.
- R10: A vertical pulse never reaches the opposite vertical direction. An upward input never drives a downward output, even with every enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Load strobe for the configuration word |
| cfgWord | input | 7*TRACKS | Branch enable bits, laid out as in R4 to R6 |
| leftIn | input | TRACKS | Pulses entering from the left |
| upIn | input | TRACKS | Pulses entering at the bottom on upward tracks |
| dnIn | input | TRACKS | Pulses entering at the top on downward tracks |
| rightOut | output | TRACKS | Registered pulses leaving to the right |
| upOut | output | TRACKS | Registered pulses leaving at the top |
| dnOut | output | TRACKS | Registered pulses leaving at the bottom |
| collide | output | 1 | Registered flag: some merger saw two or more enabled sources |

## Verification
The bench builds the block at its defaults, TRACKS=2 and ROT=1, which is the smallest size where the rotation actually moves a track. At this size every one of the 14 enable bits can be driven on its own, so a wrong index or a wrong rotation offset is seen directly at the outputs. Both kinds of merger can be made to collide. The bench also covers the timing around loading: a pulse that arrives together with a load, and a change of the configuration word while cfgValid is low.

// File: rtl/swbox_pkg.sv
package swbox_pkg;

  // Branch slots inside one track's group of enable bits
  localparam int LEFT_STRAIGHT = 0;
  localparam int LEFT_TURN_UP  = 1;
  localparam int LEFT_TURN_DN  = 2;
  localparam int VERT_STRAIGHT = 0;
  localparam int VERT_TURN_R   = 1;

  localparam int LEFT_BITS = 3;
  localparam int VERT_BITS = 2;

  function automatic int wrapIdx(input int idx, input int off, input int n);
    return (idx + off) % n;
  endfunction

  function automatic int leftBit(input int trk, input int slot);
    return LEFT_BITS * trk + slot;
  endfunction

  function automatic int upBit(input int tracks, input int trk, input int slot);
    return LEFT_BITS * tracks + VERT_BITS * trk + slot;
  endfunction

  function automatic int dnBit(input int tracks, input int trk, input int slot);
    return (LEFT_BITS + VERT_BITS) * tracks + VERT_BITS * trk + slot;
  endfunction

endpackage

// File: rtl/swbox_merge.sv
module swbox_merge #(
  parameter int SRC = 3
) (
  input  logic [SRC-1:0] src,
  input  logic [SRC-1:0] en,
  output logic           pulse,
  output logic           multi
);

  logic [SRC-1:0] gated;
  assign gated = src & en;

  always_comb begin
    logic seen;
    seen  = 1'b0;
    multi = 1'b0;
    for (int s = 0; s < SRC; s++) begin
      if (gated[s]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
    pulse = seen;
  end

  // R8: several active sources still produce an output pulse
  always_comb begin
    a_r8_multi_gives_pulse: assert (!multi || pulse);
  end

endmodule

// File: rtl/swbox_ctrl.sv
module swbox_ctrl
  import swbox_pkg::*;
#(
  parameter int TRACKS = 2,
  localparam int CFG_W = (LEFT_BITS + 2 * VERT_BITS) * TRACKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [TRACKS-1:0] enLeftRight,
  output logic [TRACKS-1:0] enLeftUp,
  output logic [TRACKS-1:0] enLeftDn,
  output logic [TRACKS-1:0] enUpUp,
  output logic [TRACKS-1:0] enUpRight,
  output logic [TRACKS-1:0] enDnDn,
  output logic [TRACKS-1:0] enDnRight
);

  logic [CFG_W-1:0] cfgQ;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (cfgValid) cfgQ <= cfgWord;
    end
  end

  for (genvar t = 0; t < TRACKS; t++) begin : g_decode
    assign enLeftRight[t] = cfgQ[leftBit(t, LEFT_STRAIGHT)];
    assign enLeftUp[t]    = cfgQ[leftBit(t, LEFT_TURN_UP)];
    assign enLeftDn[t]    = cfgQ[leftBit(t, LEFT_TURN_DN)];
    assign enUpUp[t]      = cfgQ[upBit(TRACKS, t, VERT_STRAIGHT)];
    assign enUpRight[t]   = cfgQ[upBit(TRACKS, t, VERT_TURN_R)];
    assign enDnDn[t]      = cfgQ[dnBit(TRACKS, t, VERT_STRAIGHT)];
    assign enDnRight[t]   = cfgQ[dnBit(TRACKS, t, VERT_TURN_R)];
  end

  // R2: a strobed word is what the register holds afterwards
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(cfgValid) |-> cfgQ == $past(cfgWord));

  // R2: without the strobe the configuration stays put
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(cfgValid) |-> $stable(cfgQ));

endmodule

// File: rtl/swbox_route.sv
module swbox_route
  import swbox_pkg::*;
#(
  parameter int TRACKS = 2,
  parameter int ROT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRACKS-1:0] leftIn,
  input  logic [TRACKS-1:0] upIn,
  input  logic [TRACKS-1:0] dnIn,
  input  logic [TRACKS-1:0] enLeftRight,
  input  logic [TRACKS-1:0] enLeftUp,
  input  logic [TRACKS-1:0] enLeftDn,
  input  logic [TRACKS-1:0] enUpUp,
  input  logic [TRACKS-1:0] enUpRight,
  input  logic [TRACKS-1:0] enDnDn,
  input  logic [TRACKS-1:0] enDnRight,
  output logic [TRACKS-1:0] rightOut,
  output logic [TRACKS-1:0] upOut,
  output logic [TRACKS-1:0] dnOut,
  output logic              collide
);

  localparam int BACK = TRACKS - (ROT % TRACKS);

  logic [TRACKS-1:0] rightD, upD, dnD;
  logic [TRACKS-1:0] rightMulti, upMulti, dnMulti;
  logic              armed;

  for (genvar k = 0; k < TRACKS; k++) begin : g_trk
    // source track that rotates onto track k
    localparam int SRCV = wrapIdx(k, BACK, TRACKS);

    swbox_merge #(.SRC(3)) u_right (
      .src  ({dnIn[SRCV], upIn[SRCV], leftIn[k]}),
      .en   ({enDnRight[SRCV], enUpRight[SRCV], enLeftRight[k]}),
      .pulse(rightD[k]),
      .multi(rightMulti[k])
    );

    swbox_merge #(.SRC(2)) u_top (
      .src  ({upIn[k], leftIn[SRCV]}),
      .en   ({enUpUp[k], enLeftUp[SRCV]}),
      .pulse(upD[k]),
      .multi(upMulti[k])
    );

    swbox_merge #(.SRC(2)) u_bot (
      .src  ({dnIn[k], leftIn[SRCV]}),
      .en   ({enDnDn[k], enLeftDn[SRCV]}),
      .pulse(dnD[k]),
      .multi(dnMulti[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightOut <= '0;
      upOut    <= '0;
      dnOut    <= '0;
      collide  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      rightOut <= rightD;
      upOut    <= upD;
      dnOut    <= dnD;
      collide  <= |{rightMulti, upMulti, dnMulti};
      armed    <= 1'b1;
    end
  end

  // R3: with no input pulse in the previous cycle, everything is silent
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(|{leftIn, upIn, dnIn}) |->
      (rightOut == '0) && (upOut == '0) && (dnOut == '0) && !collide);

  // R9: a collision is always accompanied by an output pulse
  a_r9_collide_pulses: assert property (@(posedge clk) disable iff (!rstN)
    collide |-> |{rightOut, upOut, dnOut});

  // R10: an upward-only stimulus never shows up at the bottom
  a_r10_no_reverse: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(|{leftIn, dnIn}) |-> dnOut == '0);

endmodule

// File: rtl/swbox_top.sv
module swbox_top
  import swbox_pkg::*;
#(
  parameter int TRACKS = 2,
  parameter int ROT    = 1,
  localparam int CFG_W = (LEFT_BITS + 2 * VERT_BITS) * TRACKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [TRACKS-1:0] leftIn,
  input  logic [TRACKS-1:0] upIn,
  input  logic [TRACKS-1:0] dnIn,
  output logic [TRACKS-1:0] rightOut,
  output logic [TRACKS-1:0] upOut,
  output logic [TRACKS-1:0] dnOut,
  output logic              collide
);

  logic [TRACKS-1:0] enLeftRight, enLeftUp, enLeftDn;
  logic [TRACKS-1:0] enUpUp, enUpRight, enDnDn, enDnRight;

  swbox_ctrl #(.TRACKS(TRACKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgValid   (cfgValid),
    .cfgWord    (cfgWord),
    .enLeftRight(enLeftRight),
    .enLeftUp   (enLeftUp),
    .enLeftDn   (enLeftDn),
    .enUpUp     (enUpUp),
    .enUpRight  (enUpRight),
    .enDnDn     (enDnDn),
    .enDnRight  (enDnRight)
  );

  swbox_route #(.TRACKS(TRACKS), .ROT(ROT)) u_route (
    .clk        (clk),
    .rstN       (rstN),
    .leftIn     (leftIn),
    .upIn       (upIn),
    .dnIn       (dnIn),
    .enLeftRight(enLeftRight),
    .enLeftUp   (enLeftUp),
    .enLeftDn   (enLeftDn),
    .enUpUp     (enUpUp),
    .enUpRight  (enUpRight),
    .enDnDn     (enDnDn),
    .enDnRight  (enDnRight),
    .rightOut   (rightOut),
    .upOut      (upOut),
    .dnOut      (dnOut),
    .collide    (collide)
  );

endmodule

// File: tb/sim_swbox_top.sv
`timescale 1ns/1ps
module sim_swbox_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic [13:0] cfgWord = '0;
  logic [1:0]  leftIn = '0, upIn = '0, dnIn = '0;
  logic [1:0]  rightOut, upOut, dnOut;
  logic        collide;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  swbox_top u0 (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWord(cfgWord),
    .leftIn(leftIn), .upIn(upIn), .dnIn(dnIn),
    .rightOut(rightOut), .upOut(upOut), .dnOut(dnOut), .collide(collide)
  );

  // {cfg, left, up, dn, expRight, expUp, expDn, expCollide}
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {14'h0001, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 1'b0}, // R4 left0 straight
    {14'h0002, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 1'b0}, // R4 left0 up turn
    {14'h0004, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b0}, // R4 left0 down turn
    {14'h0038, 2'b10, 2'b00, 2'b00, 2'b10, 2'b01, 2'b01, 1'b0}, // R4 left1 all three
    {14'h00C0, 2'b00, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 1'b0}, // R5 up0
    {14'h0300, 2'b00, 2'b10, 2'b00, 2'b01, 2'b10, 2'b00, 1'b0}, // R5 up1
    {14'h0C00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 1'b0}, // R6 dn0
    {14'h3000, 2'b00, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 1'b0}, // R6 dn1
    {14'h0000, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0}, // R7 all blocked
    {14'h3FFF, 2'b00, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 1'b0}, // R10 up never goes down
    {14'h0201, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 1'b1}, // R9 right merger collision
    {14'h0050, 2'b10, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 1'b1}, // R9 top merger collision
    {14'h0001, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 1'b0}, // R8 one enabled of two active
    {14'h3FFF, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 1'b1}, // R8 everything on
    {14'h3FFF, 2'b00, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 1'b0}  // R10 down never goes up
  };

  function automatic logic [6:0] outs();
    return {rightOut, upOut, dnOut, collide};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic loadCfg(input logic [13:0] w);
    @(negedge clk);
    cfgValid = 1'b1;
    cfgWord  = w;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R1 during reset", outs(), 7'b0);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 after reset", outs(), 7'b0);

    // R1: nothing passes before any configuration is loaded
    leftIn = 2'b11; upIn = 2'b11; dnIn = 2'b11;
    @(negedge clk);
    check("R1 unconfigured blocks all", outs(), 7'b0);
    leftIn = '0; upIn = '0; dnIn = '0;

    for (int v = 0; v < NV; v++) begin
      loadCfg(VEC[v][26:13]);
      leftIn = VEC[v][12:11];
      upIn   = VEC[v][10:9];
      dnIn   = VEC[v][8:7];
      check($sformatf("R3 vector %0d before edge", v), outs(), 7'b0);
      @(negedge clk);
      check($sformatf("vector %0d (R4/R5/R6/R7/R8/R9/R10)", v), outs(), VEC[v][6:0]);
      leftIn = '0; upIn = '0; dnIn = '0;
      @(negedge clk);
      check($sformatf("R3 vector %0d single cycle", v), outs(), 7'b0);
    end

    // R2: word changes without strobe are ignored
    loadCfg(14'h0001);
    cfgWord = 14'h0000;
    leftIn  = 2'b01;
    @(negedge clk);
    check("R2 hold without strobe", outs(), 7'b0100000);
    leftIn = '0;

    // R2: pulse in the load cycle still sees the old setting
    @(negedge clk);
    cfgValid = 1'b1;
    cfgWord  = 14'h0000;
    leftIn   = 2'b01;
    @(negedge clk);
    cfgValid = 1'b0;
    check("R2 same-cycle load uses old config", outs(), 7'b0100000);
    @(negedge clk);
    check("R2 new config blocks", outs(), 7'b0);
    leftIn = '0;
    @(negedge clk);

    // R1: reset in mid-run clears outputs and configuration
    loadCfg(14'h3FFF);
    leftIn = 2'b11;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async reset clears outputs", outs(), 7'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset clears configuration", outs(), 7'b0);
    leftIn = '0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule